// File: doc/BRIEF.md
# Coprocessor Register Transfer Sequencer

This unit sits inside a small 32-bit processor core. It carries out the two single-word moves between the core and an attached coprocessor: a read, which moves a word from the coprocessor into a core register, and a write, which moves a core register into the coprocessor. A decode stage hands it the fields of an instruction that is already decoded, together with a start strobe and the outcome of the condition test. The sequencer latches the fields and presents them to the coprocessor unchanged. It then steps through a sequential cycle, a busy-wait stretch of internal cycles and a transfer cycle, and it reports the type of each cycle on a two-bit output.

A read finishes by writing a core register. Register 15 is the exception: as a read destination it updates only the four condition flags. As a write source it supplies the instruction address plus 12. If the coprocessor reports that it is not present, the sequencer ends the instruction with an undefined-instruction pulse and writes nothing.

Top module: `cp_xfer_seq`

## Requirements
- R1: After a synchronous active-high reset, `cyc_type` is 0 (idle) and `cp_req`, `done`, `undef`, `reg_we` and `flag_we` are all low.
- R2: A `start` taken with `cond_pass` low starts nothing. `cp_req` stays low, `cyc_type` stays 0, and neither write-back strobe nor `done` is raised.
- R3: A write (`dir_rd`=0) shows `cyc_type` 1 (sequential) for one cycle, then 2 (internal) for exactly b cycles, then 3 (transfer) for one cycle. `done` follows the transfer cycle and lasts one cycle.
- R4: A read (`dir_rd`=1) shows one cycle of code 1, then exactly b+1 cycles of code 2, then one cycle of code 3, with `done` on the following cycle.
- R5: `cp_busy` is sampled in the sequential cycle and in each busy-wait cycle. b is the number of consecutive high samples before the first low one. `cycle 1` is always followed by code 2, code 3 or an `undef` pulse.
- R6: A read whose destination is not 15 raises `reg_we` in the `done` cycle. In that cycle `reg_idx` equals the destination and `reg_data` equals `cp_rdata` as sampled in the transfer cycle. `flag_we` stays low.
- R7: A read whose destination is 15 raises `flag_we` in the `done` cycle, with `flags[3:0]` = N,Z,C,V = bits 31,30,29,28 of the word. `reg_we` stays low, so no core register (including the program counter) is written.
- R8: In a write's transfer cycle, `cp_wdata` equals `rd_val` as latched at start. When the source register is 15 it equals `pc_cur + 12` instead, and `cp_dir` is 0. A write raises neither write-back strobe.
- R9: While `cp_req` is high, `cp_sel_o`, `opc_o`, `info_o`, `crn_o` and `crm_o` hold the values presented at the accepted `start`, and `cp_dir` equals that `dir_rd`.
- R10: `cp_absent` high in the sequential cycle takes priority over `cp_busy`. One `undef` pulse follows, with no transfer cycle, no write-back and no `done`, and the unit returns to idle.
- R11: A `start` that arrives while an instruction is in progress is ignored. The cycle after `done` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Decoded transfer instruction offered (taken only when idle) |
| cond_pass | input | 1 | Condition test result for the offered instruction |
| dir_rd | input | 1 | 1 = coprocessor to core, 0 = core to coprocessor |
| cp_sel | input | 4 | Coprocessor number |
| opc | input | 3 | Coprocessor opcode field |
| info | input | 3 | Extra coprocessor information field |
| crn | input | 4 | First coprocessor register number |
| crm | input | 4 | Second coprocessor register number |
| rd | input | 4 | Core register number |
| pc_cur | input | 32 | Address of the current instruction |
| rd_val | input | 32 | Value of core register `rd` |
| cp_busy | input | 1 | Coprocessor busy |
| cp_absent | input | 1 | No coprocessor answers |
| cp_rdata | input | 32 | Word returned by the coprocessor |
| cp_req | output | 1 | Handshake active |
| cp_dir | output | 1 | Latched direction |
| cp_sel_o | output | 4 | Forwarded coprocessor number |
| opc_o | output | 3 | Forwarded opcode field |
| info_o | output | 3 | Forwarded information field |
| crn_o | output | 4 | Forwarded first register number |
| crm_o | output | 4 | Forwarded second register number |
| cp_wdata | output | 32 | Word sent to the coprocessor |
| cyc_type | output | 2 | 0 idle, 1 sequential, 2 internal, 3 transfer |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Undefined-instruction pulse |
| reg_we | output | 1 | Core register write enable |
| reg_idx | output | 4 | Core register written |
| reg_data | output | 32 | Core register write data |
| flag_we | output | 1 | Condition flag write enable |
| flags | output | 4 | N,Z,C,V for the flag write |

## Verification
The hardest situation to reach is the boundary between the last busy sample and the extra internal cycle of a read. There `cp_busy` is low while `cyc_type` still reads 2, so an off-by-one in either count would hide. The bench models the coprocessor. At every mid-cycle point where the current cycle is sequential or internal, it drives `cp_busy` from a countdown of b. It sweeps b from 0 to 6 for both directions and both destination classes, including register 15, and then counts the cycle codes. The bench also pushes a second `start` with altered fields into a busy-wait stretch, and it raises `cp_absent` while busy is also high.

// File: rtl/cp_xfer_seq.sv
module cp_xfer_seq #(
  parameter int DW     = 32,
  parameter int RW     = 4,
  parameter int CPW    = 4,
  parameter int OPW    = 3,
  parameter int INW    = 3,
  parameter int PC_OFS = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           cond_pass,
  input  logic           dir_rd,
  input  logic [CPW-1:0] cp_sel,
  input  logic [OPW-1:0] opc,
  input  logic [INW-1:0] info,
  input  logic [RW-1:0]  crn,
  input  logic [RW-1:0]  crm,
  input  logic [RW-1:0]  rd,
  input  logic [DW-1:0]  pc_cur,
  input  logic [DW-1:0]  rd_val,
  input  logic           cp_busy,
  input  logic           cp_absent,
  input  logic [DW-1:0]  cp_rdata,
  output logic           cp_req,
  output logic           cp_dir,
  output logic [CPW-1:0] cp_sel_o,
  output logic [OPW-1:0] opc_o,
  output logic [INW-1:0] info_o,
  output logic [RW-1:0]  crn_o,
  output logic [RW-1:0]  crm_o,
  output logic [DW-1:0]  cp_wdata,
  output logic [1:0]     cyc_type,
  output logic           done,
  output logic           undef,
  output logic           reg_we,
  output logic [RW-1:0]  reg_idx,
  output logic [DW-1:0]  reg_data,
  output logic           flag_we,
  output logic [3:0]     flags
);

  localparam logic [RW-1:0] PC_REG = '1;
  localparam logic [1:0] CT_IDLE = 2'd0, CT_SEQ = 2'd1, CT_INT = 2'd2, CT_XFR = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEQ, ST_WAIT, ST_XTRA, ST_XFER, ST_DONE, ST_ABT
  } st_t;

  st_t           st;
  logic [RW-1:0] rd_q;
  logic [DW-1:0] rdata_q;
  logic          to_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (start && cond_pass) begin
          st       <= ST_SEQ;
          cp_dir   <= dir_rd;
          cp_sel_o <= cp_sel;
          opc_o    <= opc;
          info_o   <= info;
          crn_o    <= crn;
          crm_o    <= crm;
          rd_q     <= rd;
          cp_wdata <= (rd == PC_REG) ? pc_cur + DW'(PC_OFS) : rd_val;
        end
        ST_SEQ:  st <= cp_absent ? ST_ABT : cp_busy ? ST_WAIT : cp_dir ? ST_XTRA : ST_XFER;
        ST_WAIT: st <= cp_busy ? ST_WAIT : cp_dir ? ST_XTRA : ST_XFER;
        ST_XTRA: st <= ST_XFER;
        ST_XFER: begin
          rdata_q <= cp_rdata;
          st      <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_SEQ:           cyc_type = CT_SEQ;
      ST_WAIT, ST_XTRA: cyc_type = CT_INT;
      ST_XFER:          cyc_type = CT_XFR;
      default:          cyc_type = CT_IDLE;
    endcase
  end

  assign cp_req   = cyc_type != CT_IDLE;
  assign done     = st == ST_DONE;
  assign undef    = st == ST_ABT;
  assign to_pc    = rd_q == PC_REG;
  assign reg_we   = done && cp_dir && !to_pc;
  assign flag_we  = done && cp_dir && to_pc;
  assign reg_idx  = rd_q;
  assign reg_data = rdata_q;
  assign flags    = rdata_q[DW-1 -: 4];

endmodule

// File: rtl/cp_xfer_seq_chk.sv
module cp_xfer_seq_chk #(
  parameter int RW  = 4,
  parameter int CPW = 4,
  parameter int OPW = 3,
  parameter int INW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           cond_pass,
  input logic           cp_req,
  input logic           cp_dir,
  input logic [CPW-1:0] cp_sel_o,
  input logic [OPW-1:0] opc_o,
  input logic [INW-1:0] info_o,
  input logic [RW-1:0]  crn_o,
  input logic [RW-1:0]  crm_o,
  input logic [1:0]     cyc_type,
  input logic           done,
  input logic           undef,
  input logic           reg_we,
  input logic           flag_we
);

  // R2
  cond_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == 2'd0 && !done && !undef && start && !cond_pass) |=> !cp_req);

  // R3
  xfer_done_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 2'd3 |=> done);

  // R4
  read_extra_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == 2'd3 && cp_dir) |-> $past(cyc_type) == 2'd2);

  // R5
  seq_next_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 2'd1 |=> (cyc_type == 2'd2 || cyc_type == 2'd3 || undef));

  // R7
  wb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && flag_we));

  // R9
  fwd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_req && $past(cp_req)) |-> ($stable(cp_sel_o) && $stable(opc_o) && $stable(info_o)
                                   && $stable(crn_o) && $stable(crm_o) && $stable(cp_dir)));

  // R10
  absent_chk: assert property (@(posedge clk) disable iff (rst)
    undef |-> (!reg_we && !flag_we && !done && $past(cyc_type) == 2'd1));

  // R11
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !cp_req));

endmodule

bind cp_xfer_seq cp_xfer_seq_chk #(.RW(RW), .CPW(CPW), .OPW(OPW), .INW(INW)) u_chk (.*);

// File: tb/sim_cp_xfer_seq.sv
`timescale 1ns/1ps
module sim_cp_xfer_seq;
  logic        clk = 0, rst = 1;
  logic        start = 0, cond_pass = 0, dir_rd = 0;
  logic [3:0]  cp_sel = 0, crn = 0, crm = 0, rd = 0;
  logic [2:0]  opc = 0, info = 0;
  logic [31:0] pc_cur = 0, rd_val = 0, cp_rdata = 0;
  logic        cp_busy = 0, cp_absent = 0;
  logic        cp_req, cp_dir, done, undef, reg_we, flag_we;
  logic [3:0]  cp_sel_o, crn_o, crm_o, reg_idx, flags;
  logic [2:0]  opc_o, info_o;
  logic [31:0] cp_wdata, reg_data;
  logic [1:0]  cyc_type;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  cp_xfer_seq u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input bit d, input logic [3:0] r, input int b, input bit absent,
                     input bit cond, input bit poke, input int id);
    int rem = b, ns = 0, ni = 0, nc = 0, ndone = 0, nund = 0, badfld = 0, badord = 0;
    int prev = 0;
    bit fin = 0, poked = 0;
    logic [3:0]  e_sel = 4'(id + 2), e_crn = 4'(id + 5), e_crm = 4'(id + 9);
    logic [2:0]  e_opc = 3'(id), e_inf = 3'(id + 1);
    logic [31:0] e_wd;
    @(negedge clk);
    dir_rd = d; rd = r; cond_pass = cond; cp_sel = e_sel; opc = e_opc; info = e_inf;
    crn = e_crn; crm = e_crm; pc_cur = 32'h0000_1000 + 32'(id * 4);
    rd_val = 32'hA500_0000 ^ 32'(id * 77);
    cp_rdata = {4'(id * 5), 28'h0BC_DE01 + 28'(id)};
    e_wd = (r == 4'd15) ? pc_cur + 32'd12 : rd_val;
    start = 1; cp_busy = 0; cp_absent = 0;
    for (int n = 0; n < 60 && !fin; n++) begin
      @(negedge clk);
      start = 0;
      if (poked) begin cp_sel = e_sel; crn = e_crn; end
      case (cyc_type)
        2'd1: begin ns++; if (n != 0) badord++; end
        2'd2: begin ni++; if (prev != 1 && prev != 2) badord++; end
        2'd3: begin
          nc++; if (prev != 1 && prev != 2) badord++;
          if (!d) begin chk("R8 wdata", cp_wdata, e_wd); chk("R8 dir", 32'(cp_dir), 0); end
        end
        default: ;
      endcase
      if (cp_req && (cp_sel_o !== e_sel || opc_o !== e_opc || info_o !== e_inf ||
                     crn_o !== e_crn || crm_o !== e_crm || cp_dir !== d)) badfld++;
      if (done) begin
        ndone++; fin = 1;
        if (d && r != 4'd15) begin
          chk("R6 reg_we", 32'(reg_we), 1); chk("R6 reg_idx", 32'(reg_idx), 32'(r));
          chk("R6 reg_data", reg_data, cp_rdata); chk("R6 flag_we", 32'(flag_we), 0);
        end else if (d) begin
          chk("R7 flag_we", 32'(flag_we), 1); chk("R7 reg_we", 32'(reg_we), 0);
          chk("R7 flags", 32'(flags), 32'(cp_rdata[31:28]));
        end else begin
          chk("R8 no writeback", 32'({reg_we, flag_we}), 0);
        end
      end
      if (undef) begin
        nund++; fin = 1;
        chk("R10 no writeback", 32'({reg_we, flag_we, done}), 0);
      end
      if (!cond && cp_req) badfld++;
      if (!cond && n == 5) fin = 1;
      prev = cyc_type;
      cp_busy = 0;
      if ((cyc_type == 2'd1 || cyc_type == 2'd2) && rem > 0) begin cp_busy = 1; rem--; end
      cp_absent = (cyc_type == 2'd1) && absent;
      if (absent && cyc_type == 2'd1) cp_busy = 1;
      if (poke && cyc_type == 2'd2 && !poked) begin
        start = 1; cond_pass = 1; poked = 1; cp_sel = ~e_sel; crn = ~e_crn;
      end
    end
    if (!fin) chk("R3 finished", 0, 1);
    if (!cond) begin
      chk("R2 no cycles", 32'(ns + ni + nc + ndone + nund + badfld), 0);
    end else if (absent) begin
      chk("R10 undef count", 32'(nund), 1);
      chk("R10 cycles", 32'(ns * 100 + ni * 10 + nc), 100);
    end else begin
      chk(d ? "R4 seq count" : "R3 seq count", 32'(ns), 1);
      chk(d ? "R4 int count" : "R3 int count", 32'(ni), 32'(b + (d ? 1 : 0)));
      chk(d ? "R4 xfer count" : "R3 xfer count", 32'(nc), 1);
      chk("R5 order", 32'(badord), 0);
      chk(poke ? "R11 fields" : "R9 fields", 32'(badfld), 0);
    end
    start = 0; cp_busy = 0; cp_absent = 0;
    @(negedge clk);
    chk("R11 idle after", 32'({cyc_type, done, undef, cp_req}), 0);
  endtask

  initial begin
    #1600000;
    nerr++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int id = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 reset state", 32'({cyc_type, cp_req, done, undef, reg_we, flag_we}), 0);
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 2; k++)
        for (int b = 0; b <= 6; b++) begin
          run(d[0], k ? 4'd15 : 4'(3 + b), b, 0, 1, 0, id);
          id++;
        end
    run(0, 4'd2, 2, 1, 1, 0, 40);
    run(1, 4'd9, 2, 1, 1, 0, 41);
    run(0, 4'd4, 1, 0, 0, 0, 42);
    run(1, 4'd15, 0, 0, 0, 0, 43);
    run(1, 4'd6, 3, 0, 1, 1, 44);
    run(0, 4'd15, 3, 0, 1, 1, 45);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule